// File: doc/BRIEF.md
# Three-Segment Pipelined Multiply-Add

This block computes `a * b + c` over a stream of unsigned operand triples and takes a new triple on every clock. The work is split across three register segments. The first captures the two multiplicands. The second forms their full-width product and, on the same edge, captures the addend. The third adds the product to the addend and registers the sum. The addend enters one segment after the multiplicands, so it is timed against the product register and not against the input.

A valid bit travels with each task through all three segments. The result bus is qualified by its own valid bit. There is no backpressure. A task that enters is always delivered two clocks after its multiplicands are loaded, unless a reset intervenes. The result is one bit wider than the product, so the final add never overflows.

The parameter `ADDEND_LATE` selects how the addend reaches the block:
- With 0, all three operands are presented together, and a one-stage hold register delays `c` to meet its task in segment 2.
- With 1, the source presents `c` one clock after the `a`/`b` pair of the same task. That value goes straight into the addend register.

Top module: `muladd_pipe`

## Requirements
- R1: While `rst_n` is low at a rising edge, every valid bit is cleared (synchronous, active low). `res_valid` stays low until a task accepted after reset has crossed all three segments.
- R2: The result is `a*b + c`, computed in 2W+1 bits with no loss. This includes all-ones operands, where it equals (2^W-1)^2 + 2^W-1.
- R3: A task whose triple is sampled with `op_valid` high at rising edge k appears on `res_sum` with `res_valid` high right after rising edge k+2. That is three edges, counting edge k, and two clocks after its multiplicands are loaded.
- R4: One task is accepted on every clock. n back-to-back tasks complete in n+2 clocks, in the order they entered, with no gap.
- R5: An edge with `op_valid` low creates a bubble. `res_valid` is low exactly two edges later.
- R6: With `ADDEND_LATE`=1, `c` is sampled one edge after the `a`/`b` pair of the same task, and the result and timing are otherwise as in R2 and R3.
- R7: Operand values presented while `op_valid` is low have no effect: no result is marked valid for them.
- R8: A reset asserted while tasks are in flight discards them all. No result from before the reset is ever marked valid afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low, clears the valid bits |
| op_valid | input | 1 | The operand triple on this edge is a task |
| op_a | input | W | Multiplicand A, unsigned |
| op_b | input | W | Multiplicand B, unsigned |
| op_c | input | W | Addend C, unsigned (one cycle later when `ADDEND_LATE`=1) |
| res_valid | output | 1 | `res_sum` holds a finished task |
| res_sum | output | 2W+1 | A*B+C of the task leaving segment 3 |

## Verification
The main function is driven with several input patterns:
- A single isolated task shows the exact latency, since no neighbour can mask an off-by-one.
- Extreme operands (all ones, zeros, one) expose a narrowed product or a dropped carry.
- A run of seven back-to-back tasks separates full throughput and in-order delivery from any design that stalls or reorders.
- Alternating bubbles and invalid cycles carrying random data show that the valid bit, and not the data, decides what is delivered.
- A reset in the middle of a stream checks that in-flight work is discarded.
- A long random stream with about 70% occupancy runs on both addend timings at once. It separates an addend that is aligned correctly from one paired with the neighbouring task's product.

// File: rtl/muladd_pkg.sv
// muladd_pkg: widths and constants shared by the multiply-add pipeline.
// Assumes operands are unsigned and W is at least 1.
package muladd_pkg;

    // Number of register segments a task crosses from input to result.
    localparam int unsigned SEGMENTS = 3;

    // Width of the full product of two W-bit operands.
    function automatic int unsigned prod_width(input int unsigned w);
        return 2 * w;
    endfunction

    // Width of product plus addend, wide enough that the add never overflows.
    function automatic int unsigned sum_width(input int unsigned w);
        return 2 * w + 1;
    endfunction

endpackage

// File: rtl/muladd_load_seg.sv
// muladd_load_seg: segment 1. Registers the multiplicand pair and the valid
// bit. When ADDEND_LATE is 0 it also holds C for one stage, so that C meets
// its task at segment 2. When ADDEND_LATE is 1 it passes C through, because
// the source already sends C one cycle late.
// Assumes a synchronous active-low reset; the data registers are not reset.
module muladd_load_seg #(
    parameter int unsigned W           = 16,
    parameter bit          ADDEND_LATE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [W-1:0] in_c,
    output logic         s1_valid,
    output logic [W-1:0] s1_a,
    output logic [W-1:0] s1_b,
    output logic [W-1:0] s1_c
);

    // Valid bit of segment 1: cleared by reset, otherwise follows the input.
    always_ff @(posedge clk) begin
        if (!rst_n) s1_valid <= 1'b0;
        else        s1_valid <= in_valid;
    end

    // Multiplicand registers: load A and B on the same edge.
    always_ff @(posedge clk) begin
        s1_a <= in_a;
        s1_b <= in_b;
    end

    generate
        if (ADDEND_LATE == 1'b0) begin : g_align
            logic [W-1:0] c_hold;
            // Addend hold register: delays C by one stage to line it up with its task.
            always_ff @(posedge clk) begin
                c_hold <= in_c;
            end
            assign s1_c = c_hold;
        end else begin : g_direct
            // The source already delays C by one cycle; pass it through to segment 2.
            assign s1_c = in_c;
        end
    endgenerate

endmodule

// File: rtl/muladd_mul_seg.sv
// muladd_mul_seg: segment 2. Registers the full product of the segment-1
// multiplicands, and on the same edge captures the addend.
// Assumes unsigned operands; the product is 2W bits, so nothing is truncated.
module muladd_mul_seg
    import muladd_pkg::*;
#(
    parameter int unsigned W  = 16,
    localparam int unsigned PW = prod_width(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [W-1:0]  in_a,
    input  logic [W-1:0]  in_b,
    input  logic [W-1:0]  in_c,
    output logic          out_valid,
    output logic [PW-1:0] out_prod,
    output logic [W-1:0]  out_addend
);

    logic [PW-1:0] prod_next;

    // Full-width unsigned multiply of the registered pair.
    always_comb begin
        prod_next = PW'(in_a) * PW'(in_b);
    end

    // Valid bit of segment 2: cleared by reset, otherwise follows segment 1.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Product and addend registers, loaded on the same edge.
    always_ff @(posedge clk) begin
        out_prod   <= prod_next;
        out_addend <= in_c;
    end

    // R5
    mul_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R4
    mul_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

endmodule

// File: rtl/muladd_add_seg.sv
// muladd_add_seg: segment 3. Adds the product register to the addend
// register and registers the (2W+1)-bit sum with its valid bit.
// Assumes that the product and the addend at its inputs belong to the same task.
module muladd_add_seg
    import muladd_pkg::*;
#(
    parameter int unsigned W  = 16,
    localparam int unsigned PW = prod_width(W),
    localparam int unsigned SW = sum_width(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [PW-1:0] in_prod,
    input  logic [W-1:0]  in_addend,
    output logic          out_valid,
    output logic [SW-1:0] out_sum
);

    logic [SW-1:0] sum_next;

    // Widened add, so the carry out of the product is kept.
    always_comb begin
        sum_next = SW'(in_prod) + SW'(in_addend);
    end

    // Valid bit of segment 3: cleared by reset, otherwise follows segment 2.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Result register.
    always_ff @(posedge clk) begin
        out_sum <= sum_next;
    end

    // R5
    add_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R4
    add_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

endmodule

// File: rtl/muladd_pipe.sv
// muladd_pipe: three-segment pipelined A*B+C with valid-qualified operands
// and result. It accepts one task per clock, has no backpressure, and delivers
// each result two clocks after its multiplicands are loaded.
// Assumes a synchronous active-low reset. ADDEND_LATE selects whether C
// arrives together with A/B (0) or one cycle after them (1).
module muladd_pipe
    import muladd_pkg::*;
#(
    parameter int unsigned W           = 16,
    parameter bit          ADDEND_LATE = 1'b0,
    localparam int unsigned PW = prod_width(W),
    localparam int unsigned SW = sum_width(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [W-1:0]  op_a,
    input  logic [W-1:0]  op_b,
    input  logic [W-1:0]  op_c,
    output logic          res_valid,
    output logic [SW-1:0] res_sum
);

    logic          s1_valid;
    logic [W-1:0]  s1_a;
    logic [W-1:0]  s1_b;
    logic [W-1:0]  s1_c;
    logic          s2_valid;
    logic [PW-1:0] s2_prod;
    logic [W-1:0]  s2_addend;

    muladd_load_seg #(.W(W), .ADDEND_LATE(ADDEND_LATE)) u_load (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (op_valid),
        .in_a     (op_a),
        .in_b     (op_b),
        .in_c     (op_c),
        .s1_valid (s1_valid),
        .s1_a     (s1_a),
        .s1_b     (s1_b),
        .s1_c     (s1_c)
    );

    muladd_mul_seg #(.W(W)) u_mul (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (s1_valid),
        .in_a       (s1_a),
        .in_b       (s1_b),
        .in_c       (s1_c),
        .out_valid  (s2_valid),
        .out_prod   (s2_prod),
        .out_addend (s2_addend)
    );

    muladd_add_seg #(.W(W)) u_add (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (s2_valid),
        .in_prod   (s2_prod),
        .in_addend (s2_addend),
        .out_valid (res_valid),
        .out_sum   (res_sum)
    );

    // Edges since reset, saturating at the pipeline depth. Used only by the checks.
    logic [1:0] since_rst;

    // Counts edges since reset, so the checks never look back past the reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                  since_rst <= 2'd0;
        else if (since_rst != 2'd3)  since_rst <= since_rst + 2'd1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd3) |-> !res_valid);

    // R3
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (res_valid == $past(op_valid, 3)));

    generate
        if (ADDEND_LATE == 1'b0) begin : g_chk_together
            // R2
            result_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (since_rst == 2'd3 && res_valid) |->
                (res_sum == SW'(SW'($past(op_a, 3)) * SW'($past(op_b, 3)) + SW'($past(op_c, 3)))));
        end else begin : g_chk_late
            // R6
            late_addend_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (since_rst == 2'd3 && res_valid) |->
                (res_sum == SW'(SW'($past(op_a, 3)) * SW'($past(op_b, 3)) + SW'($past(op_c, 2)))));
        end
    endgenerate

endmodule

// File: tb/muladd_pipe_bench.sv
`timescale 1ns/1ps
// muladd_pipe_bench: drives the same task stream into both addend timings,
// and compares each result and valid bit with values computed here.
module muladd_pipe_bench;

    localparam int unsigned W     = 16;
    localparam int unsigned SW    = 2 * W + 1;
    localparam int unsigned DEPTH = 2048;
    localparam logic [W-1:0] ONES = {W{1'b1}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [W-1:0]  op_a = '0;
    logic [W-1:0]  op_b = '0;
    logic [W-1:0]  op_c = '0;
    logic [W-1:0]  late_c = '0;
    logic          res_valid;
    logic [SW-1:0] res_sum;
    logic          late_valid;
    logic [SW-1:0] late_sum;

    int checks = 0;
    int fails  = 0;
    int step_i = 0;
    bit done   = 1'b0;
    string tag = "R1";

    logic          hist_v [DEPTH];
    logic [SW-1:0] hist_s [DEPTH];
    logic [W-1:0]  hist_c [DEPTH];

    always #2.5 clk = ~clk;

    muladd_pipe #(.W(W), .ADDEND_LATE(1'b0)) u_muladd_pipe (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
        .op_c(op_c), .res_valid(res_valid), .res_sum(res_sum)
    );

    muladd_pipe #(.W(W), .ADDEND_LATE(1'b1)) u_muladd_pipe_late (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
        .op_c(late_c), .res_valid(late_valid), .res_sum(late_sum)
    );

    function automatic logic [SW-1:0] ref_muladd(input logic [W-1:0] a, input logic [W-1:0] b,
                                                 input logic [W-1:0] c);
        return SW'(SW'(a) * SW'(b) + SW'(c));
    endfunction

    task automatic check(input string req, input logic [SW-1:0] got, input logic [SW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s step %0d: got %0h expected %0h", req, step_i, got, exp);
        end
    endtask

    // One clock: check the outputs left by the previous edges, then drive the next inputs.
    task automatic do_step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic [W-1:0] c, input logic run);
        logic ev;
        @(negedge clk);
        ev = (step_i >= 3) ? hist_v[step_i-3] : 1'b0;
        check(tag, SW'(res_valid), SW'(ev));
        check("R6", SW'(late_valid), SW'(ev));
        if (ev) begin
            check("R2", res_sum, hist_s[step_i-3]);
            check("R6", late_sum, hist_s[step_i-3]);
        end
        rst_n    = run;
        op_valid = v;
        op_a     = a;
        op_b     = b;
        op_c     = c;
        late_c   = (step_i >= 1) ? hist_c[step_i-1] : '0;
        hist_v[step_i] = v & run;
        hist_s[step_i] = ref_muladd(a, b, c);
        hist_c[step_i] = c;
        if (!run) begin
            // R8: the reset edge discards every task still in flight.
            if (step_i >= 1) hist_v[step_i-1] = 1'b0;
            if (step_i >= 2) hist_v[step_i-2] = 1'b0;
        end
        step_i++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) do_step(1'b0, '0, '0, '0, 1'b1);
    endtask

    function automatic logic [W-1:0] rnd();
        return W'($urandom);
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) begin
            hist_v[i] = 1'b0;
            hist_s[i] = '0;
            hist_c[i] = '0;
        end
        // R1: reset state, then quiet outputs after release.
        tag = "R1";
        for (int i = 0; i < 3; i++) do_step(1'b1, rnd(), rnd(), rnd(), 1'b0);
        idle(4);
        // R3: a single isolated task.
        tag = "R3";
        do_step(1'b1, 16'd3, 16'd5, 16'd7, 1'b1);
        idle(4);
        // R2: extreme operands.
        tag = "R2";
        do_step(1'b1, ONES, ONES, ONES, 1'b1);
        do_step(1'b1, '0, '0, '0, 1'b1);
        do_step(1'b1, ONES, ONES, '0, 1'b1);
        do_step(1'b1, 16'd1, 16'd1, ONES, 1'b1);
        idle(4);
        // R4: seven back-to-back tasks.
        tag = "R4";
        for (int i = 1; i <= 7; i++) do_step(1'b1, W'(i), W'(i + 10), W'(i * 3), 1'b1);
        idle(4);
        // R5: bubbles between tasks.
        tag = "R5";
        do_step(1'b1, rnd(), rnd(), rnd(), 1'b1);
        do_step(1'b0, rnd(), rnd(), rnd(), 1'b1);
        do_step(1'b0, rnd(), rnd(), rnd(), 1'b1);
        do_step(1'b1, rnd(), rnd(), rnd(), 1'b1);
        do_step(1'b0, rnd(), rnd(), rnd(), 1'b1);
        do_step(1'b1, rnd(), rnd(), rnd(), 1'b1);
        idle(4);
        // R7: data without valid is ignored.
        tag = "R7";
        for (int i = 0; i < 6; i++) do_step(1'b0, ONES, rnd(), rnd(), 1'b1);
        idle(3);
        // R8: reset while three tasks are in flight.
        tag = "R8";
        for (int i = 0; i < 3; i++) do_step(1'b1, rnd(), rnd(), rnd(), 1'b1);
        do_step(1'b1, rnd(), rnd(), rnd(), 1'b0);
        idle(5);
        // R2: random stream at about 70% occupancy.
        tag = "R5";
        for (int i = 0; i < 400; i++) do_step(($urandom % 10) < 7, rnd(), rnd(), rnd(), 1'b1);
        idle(4);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: ends a hung run as a failed check.
    initial begin
        #(5.0 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule